// File: doc/BRIEF.md
# Ring Buffer Pointer Tracker with Watermark

This block follows a single audio ring buffer that lives in system memory. Software programs five values through a small write port: the base address, the inclusive last address, the read pointer, the write pointer and a mark. A streaming beat interface moves one of the two pointers forward by a byte count on each accepted beat. In playback the beat is the consumer and moves the read pointer. In capture the beat is the producer and moves the write pointer. Software moves the other pointer by writing its register directly.

Each pointer is one bit wider than the address. The top bit is a wrap toggle that tells a full ring from an empty one when the addresses match. The block registers the fill and free levels and reports the byte position of the active pointer. It raises a one-cycle watermark event when the level that matters for the current direction goes strictly above the mark. After that, detection stays off until a rearm strobe. A beat that reads more than is buffered, or writes more than there is room for, raises a one-cycle error pulse.

Back-pressure rule: `beat_ready` is low in any cycle that carries a configuration write, and high otherwise. A beat is taken on a rising edge where `beat_valid` and `beat_ready` are both high. The pointer still advances on a beat that raises an error. The source may hold `beat_valid` while `beat_ready` is low, and the beat is then taken in the next cycle without a configuration write.

Top module: `ring_ptr_tracker`

## Requirements
- R1: A pointer is 32 bits wide. Bit 31 is the wrap toggle and bits 30:0 are the byte address. When an advance carries the address past the last address, the address continues from the base and the toggle inverts.
- R2: The ring size is last minus base plus 1. Equal addresses with equal toggles give a fill of 0. Equal addresses with different toggles give a fill equal to the size. The free level is the size minus the fill.
- R3: `fill_level` and `free_level` follow the pointers one cycle after any change, whether the change comes from a beat or from a software pointer write.
- R4: The watermark compares the free level in playback (`dir_play`=1) and the fill level in capture (`dir_play`=0). It fires only when that level is strictly greater than the mark; a level equal to the mark does not fire.
- R5: Detection is disarmed out of reset. A watermark event disarms it, and no further event occurs until a rearm.
- R6: A one-cycle `rearm` pulse re-enables detection. If the level is still above the mark, a new event follows.
- R7: In playback, an accepted beat whose byte count is larger than the current fill gives a one-cycle `err_underflow` pulse in the next cycle.
- R8: In capture, an accepted beat whose byte count is larger than the current free level gives a one-cycle `err_overflow` pulse in the next cycle.
- R9: `pos` equals bits 30:0 of the active pointer minus bits 30:0 of the base. The active pointer is the read pointer in playback and the write pointer in capture.
- R10: `beat_ready` is low during a configuration write cycle. An accepted beat moves only the read pointer in playback and only the write pointer in capture.
- R11: `cfg_sel` selects the register to write: 0 is the base, 1 the last address, 2 the read pointer, 3 the write pointer and 4 the mark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dir_play | input | 1 | 1 selects playback, 0 selects capture |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Register select (R11 encoding) |
| cfg_wdata | input | 32 | Configuration write data |
| rearm | input | 1 | Re-enables watermark detection |
| beat_valid | input | 1 | Beat offered |
| beat_ready | output | 1 | Beat can be taken this cycle |
| beat_bytes | input | 16 | Bytes moved by the beat |
| rd_ptr | output | 32 | Read pointer with toggle |
| wr_ptr | output | 32 | Write pointer with toggle |
| pos | output | 31 | Byte offset of the active pointer from the base |
| fill_level | output | 32 | Registered filled bytes |
| free_level | output | 32 | Registered free bytes |
| wm_event | output | 1 | Watermark event pulse |
| err_underflow | output | 1 | Playback read-past-data pulse |
| err_overflow | output | 1 | Capture write-into-full pulse |

## Verification
Playback starts from a full ring and is drained in 256-byte beats, so that a free level just below the mark, exactly at it and just above it can be told apart. A further beat then shows the one-shot behaviour, and a rearm shows that detection comes back. A large beat carries the read pointer across the last address, which shows the address wrapping and the toggle inverting. A refill by software checks that the level is recomputed. A beat larger than the fill must produce an underflow pulse. Capture then repeats the mark boundary on the fill level. It wraps the write pointer into a full ring with a beat that fits exactly and must not flag. One more byte count must flag overflow.

// File: rtl/rbt_pkg.sv
package rbt_pkg;
  typedef enum logic [2:0] {
    SEL_BASE = 3'd0,
    SEL_LAST = 3'd1,
    SEL_RD   = 3'd2,
    SEL_WR   = 3'd3,
    SEL_MARK = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/rbt_advance.sv
// Moves one toggle-tagged pointer forward by a byte count, wrapping at the last address.
module rbt_advance #(
  parameter int AW = 31,
  parameter int BW = 16
) (
  input  logic [AW:0]   cur,
  input  logic [BW-1:0] bytes,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] last,
  output logic [AW:0]   nxt,
  output logic          wrapped
);
  localparam int PW = AW + 1;
  logic [AW:0] sum, size, addr;

  always_comb begin
    size    = {1'b0, last} - {1'b0, base} + PW'(1);
    sum     = {1'b0, cur[AW-1:0]} + PW'(bytes);
    wrapped = sum > {1'b0, last};
    addr    = wrapped ? (sum - size) : sum;
    nxt     = {cur[AW] ^ wrapped, addr[AW-1:0]};
  end
endmodule

// File: rtl/rbt_level.sv
// Fill and free levels from the two pointers: combinational now, registered for outputs.
module rbt_level #(
  parameter int AW = 31
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW:0]   rd,
  input  logic [AW:0]   wr,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] last,
  output logic [AW:0]   fill_now,
  output logic [AW:0]   free_now,
  output logic [AW:0]   fill_q,
  output logic [AW:0]   free_q
);
  localparam int PW = AW + 1;
  logic [AW:0] size, diff;

  always_comb begin
    size     = {1'b0, last} - {1'b0, base} + PW'(1);
    diff     = {1'b0, wr[AW-1:0]} - {1'b0, rd[AW-1:0]};
    fill_now = (rd[AW] == wr[AW]) ? diff : (diff + size);
    free_now = size - fill_now;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_q <= '0;
      free_q <= '0;
    end else begin
      fill_q <= fill_now;
      free_q <= free_now;
    end
  end
endmodule

// File: rtl/rbt_mark.sv
// One-shot watermark detector, armed by an explicit strobe.
module rbt_mark #(
  parameter int AW = 31
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dir_play,
  input  logic [AW:0]   fill_q,
  input  logic [AW:0]   free_q,
  input  logic [AW-1:0] mark,
  input  logic          rearm,
  output logic          wm_event
);
  logic        armed_q;
  logic [AW:0] level;
  logic        fire;

  always_comb begin
    level = dir_play ? free_q : fill_q;
    fire  = armed_q && (level > {1'b0, mark});
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q  <= 1'b0;
      wm_event <= 1'b0;
    end else begin
      wm_event <= fire;
      if (rearm)     armed_q <= 1'b1;
      else if (fire) armed_q <= 1'b0;
    end
  end

  // R5: while disarmed and not rearmed, no event appears in the next cycle
  a_r5_disarmed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !rearm) |=> !wm_event);

  // R6: a rearm leaves detection armed on the following cycle
  a_r6_rearm_arms: assert property (@(posedge clk) disable iff (!rst_n)
    rearm |=> armed_q);
endmodule

// File: rtl/ring_ptr_tracker.sv
module ring_ptr_tracker #(
  parameter int AW = 31,
  parameter int BW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dir_play,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_sel,
  input  logic [AW:0]   cfg_wdata,
  input  logic          rearm,
  input  logic          beat_valid,
  output logic          beat_ready,
  input  logic [BW-1:0] beat_bytes,
  output logic [AW:0]   rd_ptr,
  output logic [AW:0]   wr_ptr,
  output logic [AW-1:0] pos,
  output logic [AW:0]   fill_level,
  output logic [AW:0]   free_level,
  output logic          wm_event,
  output logic          err_underflow,
  output logic          err_overflow
);
  import rbt_pkg::*;
  localparam int NPTR  = 2;
  localparam int IDX_R = 0;
  localparam int IDX_W = 1;
  localparam int PW    = AW + 1;

  logic [AW-1:0] base_q, last_q, mark_q;
  logic [AW:0]   ptr_q   [NPTR];
  logic [AW:0]   ptr_nxt [NPTR];
  logic          ptr_wrap[NPTR];
  logic [AW:0]   fill_now, free_now;
  logic          acc;
  reg_sel_e      sel;

  assign sel        = reg_sel_e'(cfg_sel);
  assign beat_ready = !cfg_we;
  assign acc        = beat_valid && beat_ready;

  for (genvar g = 0; g < NPTR; g++) begin : g_adv
    rbt_advance #(.AW(AW), .BW(BW)) u_adv (
      .cur(ptr_q[g]), .bytes(beat_bytes), .base(base_q), .last(last_q),
      .nxt(ptr_nxt[g]), .wrapped(ptr_wrap[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      last_q <= '0;
      mark_q <= '0;
      for (int i = 0; i < NPTR; i++) ptr_q[i] <= '0;
      err_underflow <= 1'b0;
      err_overflow  <= 1'b0;
    end else begin
      err_underflow <= acc && dir_play  && (PW'(beat_bytes) > fill_now);
      err_overflow  <= acc && !dir_play && (PW'(beat_bytes) > free_now);
      if (cfg_we) begin
        case (sel)
          SEL_BASE: base_q       <= cfg_wdata[AW-1:0];
          SEL_LAST: last_q       <= cfg_wdata[AW-1:0];
          SEL_RD:   ptr_q[IDX_R] <= cfg_wdata;
          SEL_WR:   ptr_q[IDX_W] <= cfg_wdata;
          SEL_MARK: mark_q       <= cfg_wdata[AW-1:0];
          default:  ;
        endcase
      end else if (acc) begin
        if (dir_play) ptr_q[IDX_R] <= ptr_nxt[IDX_R];
        else          ptr_q[IDX_W] <= ptr_nxt[IDX_W];
      end
    end
  end

  rbt_level #(.AW(AW)) u_level (
    .clk(clk), .rst_n(rst_n), .rd(ptr_q[IDX_R]), .wr(ptr_q[IDX_W]),
    .base(base_q), .last(last_q), .fill_now(fill_now), .free_now(free_now),
    .fill_q(fill_level), .free_q(free_level)
  );

  rbt_mark #(.AW(AW)) u_mark (
    .clk(clk), .rst_n(rst_n), .dir_play(dir_play), .fill_q(fill_level),
    .free_q(free_level), .mark(mark_q), .rearm(rearm), .wm_event(wm_event)
  );

  assign rd_ptr = ptr_q[IDX_R];
  assign wr_ptr = ptr_q[IDX_W];
  assign pos    = (dir_play ? ptr_q[IDX_R][AW-1:0] : ptr_q[IDX_W][AW-1:0]) - base_q;

  // R1: a playback beat that wraps inverts the read toggle
  a_r1_wrap_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && dir_play && ptr_wrap[IDX_R]) |=> (rd_ptr[AW] != $past(rd_ptr[AW])));

  // R7: an underflow pulse only follows a playback beat
  a_r7_underflow_play: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !dir_play) |=> !err_underflow);

  // R8: an overflow pulse only follows a capture beat
  a_r8_overflow_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && dir_play) |=> !err_overflow);

  // R10: a playback beat leaves the write pointer alone
  a_r10_play_keeps_wr: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && dir_play) |=> $stable(wr_ptr));
endmodule

// File: tb/tb_ring_ptr_tracker.sv
module tb_ring_ptr_tracker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dir_play = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        rearm = 1'b0;
  logic        beat_valid = 1'b0;
  logic        beat_ready;
  logic [15:0] beat_bytes = '0;
  logic [31:0] rd_ptr, wr_ptr, fill_level, free_level;
  logic [30:0] pos;
  logic        wm_event, err_underflow, err_overflow;

  int checks = 0;
  int errors = 0;
  int wm_cnt = 0, unf_cnt = 0, ovf_cnt = 0;

  typedef struct {
    string       req;
    logic [31:0] pos;
    logic [31:0] fill;
    logic [31:0] free;
  } exp_t;
  exp_t expq[$];

  always #2 clk = ~clk;

  ring_ptr_tracker dut (
    .clk(clk), .rst_n(rst_n), .dir_play(dir_play), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .rearm(rearm),
    .beat_valid(beat_valid), .beat_ready(beat_ready), .beat_bytes(beat_bytes),
    .rd_ptr(rd_ptr), .wr_ptr(wr_ptr), .pos(pos), .fill_level(fill_level),
    .free_level(free_level), .wm_event(wm_event),
    .err_underflow(err_underflow), .err_overflow(err_overflow)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (wm_event)      wm_cnt++;
      if (err_underflow) unf_cnt++;
      if (err_overflow)  ovf_cnt++;
    end
  end

  // monitor: compares scoreboard items against the outputs
  always @(negedge clk) begin
    if (expq.size() > 0) begin
      exp_t e;
      e = expq.pop_front();
      chk({e.req, " pos"},  {1'b0, pos}, e.pos);
      chk({e.req, " fill"}, fill_level,  e.fill);
      chk({e.req, " free"}, free_level,  e.free);
    end
  end

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic push(string req, logic [31:0] p, logic [31:0] f);
    exp_t e;
    e.req = req; e.pos = p; e.fill = f; e.free = 32'h1000 - f;
    expq.push_back(e);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic cfg(logic [2:0] s, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    #1 chk("R10 ready low on cfg write", {31'b0, beat_ready}, 32'd0);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic beat(logic [15:0] b);
    @(negedge clk);
    beat_valid = 1'b1; beat_bytes = b;
    @(negedge clk);
    beat_valid = 1'b0;
    settle();
  endtask

  task automatic pulse_rearm();
    @(negedge clk);
    rearm = 1'b1;
    @(negedge clk);
    rearm = 1'b0;
    settle();
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("reset rd_ptr", rd_ptr, 0);
    chk("reset wr_ptr", wr_ptr, 0);
    chk("reset fill", fill_level, 0);
    chk("R5 reset no event", {31'b0, wm_event}, 0);

    // R11 playback setup: full ring of 4 KiB at 0x1000, mark 0x300
    cfg(3'd0, 32'h0000_1000);
    cfg(3'd1, 32'h0000_1FFF);
    cfg(3'd4, 32'h0000_0300);
    cfg(3'd2, 32'h0000_1000);
    cfg(3'd3, 32'h8000_1000);
    settle();
    chk("R11 rd written", rd_ptr, 32'h0000_1000);
    chk("R11 wr written", wr_ptr, 32'h8000_1000);
    chk("R5 disarmed after reset", wm_cnt, 0);
    push("R2 full ring", 32'h0, 32'h1000);

    pulse_rearm();
    chk("R4 free 0 no event", wm_cnt, 0);
    beat(16'h0100);
    push("R9 playback pos", 32'h100, 32'hF00);
    beat(16'h0100);
    beat(16'h0100);
    push("R3 level after beats", 32'h300, 32'hD00);
    chk("R4 free equal to mark no event", wm_cnt, 0);
    beat(16'h0100);
    chk("R4 free above mark fires", wm_cnt, 1);
    beat(16'h0100);
    chk("R5 no second event", wm_cnt, 1);
    chk("R10 play keeps wr", wr_ptr, 32'h8000_1000);
    pulse_rearm();
    chk("R6 rearm refires", wm_cnt, 2);

    cfg(3'd3, 32'h8000_1500);
    @(negedge clk);
    push("R3 sw refill", 32'h500, 32'h1000);
    beat(16'h0B00);
    chk("R1 read wraps and toggles", rd_ptr, 32'h8000_1000);
    push("R1 after wrap", 32'h0, 32'h500);
    chk("R7 no underflow yet", unf_cnt, 0);
    beat(16'h0600);
    chk("R7 underflow flagged", unf_cnt, 1);

    // capture: empty ring
    dir_play = 1'b0;
    cfg(3'd2, 32'h0000_1000);
    cfg(3'd3, 32'h0000_1000);
    settle();
    push("R2 empty ring", 32'h0, 32'h0);
    pulse_rearm();
    chk("R4 capture empty no event", wm_cnt, 2);
    beat(16'h0300);
    push("R9 capture pos", 32'h300, 32'h300);
    chk("R4 fill equal to mark no event", wm_cnt, 2);
    chk("R10 capture keeps rd", rd_ptr, 32'h0000_1000);
    beat(16'h0100);
    chk("R4 capture fill above mark fires", wm_cnt, 3);
    beat(16'h0C00);
    chk("R1 write wraps and toggles", wr_ptr, 32'h8000_1000);
    push("R2 capture full", 32'h0, 32'h1000);
    chk("R8 exact fit no overflow", ovf_cnt, 0);
    beat(16'h0100);
    chk("R8 overflow flagged", ovf_cnt, 1);
    chk("R7 no underflow in capture", unf_cnt, 1);

    settle();
    chk("scoreboard drained", expq.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule